// File: doc/BRIEF.md
# Sync clock phase alignment controller

This block divides a fast system clock by four to make a slower synchronisation clock. It can shift the phase of that clock forward by exactly one system-clock period at a time, which lets several devices fed from one system clock line up their divided clocks. A two-bit phase counter makes the divided clock. A shift skips one count, so the counter moves forward by two in that cycle.

The phase can be moved from three sources, each chosen by a bit in a 32-bit control word:
- **Automatic slave mode.** The block reloads its counter so that its own wrap lines up with a master sync edge seen on an external pin.
- **Hardware step mode.** Each rising edge on that same pin gives one step.
- **Software step.** A self-clearing request bit gives one step.

In the automatic and hardware modes the shared pin is an input. In every other mode it drives the PLL lock indication out. A sticky lock-error bit in the control word records any loss of lock, so that loss stays visible while the pin serves as an input.

Top module: `syncclk_align`

## Requirements
- R1: The phase counter `sync_phase` counts 0,1,2,3,0,... with one step per system clock when no step or reload applies. `sync_clk` is 1 while the counter is 0 or 1 and 0 while it is 2 or 3.
- R2: Writing a control word with bit 2 set (and bits 1 and 3 clear) sets the request bit, which reads back as 1 for exactly one cycle after the write edge. At the following edge the counter advances by 2 instead of 1, and the bit reads 0 again.
- R3: Writes with bit 2 set on consecutive cycles each produce one extra advance.
- R4: With bit 1 set and bit 3 clear, the pin is sampled through a two-flop synchroniser. The counter advances by 2 instead of 1 at the third clock edge after the pin is first sampled high. A pin held high gives only one step.
- R5: With bit 3 set and bit 0 clear, a pin rising edge first sampled at edge k reloads the counter to 2 at edge k+2, so that the counter reads 0 at edge k+4.
- R6: With bits 3 and 0 both set, one extra synchroniser stage is used. The reload happens at edge k+3 with value 3, so the counter still reads 0 at edge k+4.
- R7: The source priority is: bit 3 first, then bit 1, then bit 2. A bit-2 request made while bit 1 or bit 3 is set is cleared after one cycle and does not step the counter. With bits 3 and 1 both set, a pin edge reloads and does not step.
- R8: While bit 3 or bit 1 is set, `pin_oe` is 0 and `pin_out` is 0. Otherwise `pin_oe` is 1 and `pin_out` equals `pll_locked`.
- R9: Bit 24 is a sticky lock error. It is set at the edge after `pll_locked` is seen low and stays set in every mode. A write with bit 24 = 1 clears it, a write with bit 24 = 0 leaves it, and a new loss of lock in the same cycle as a clear wins.
- R10: With bits 1 and 3 clear, edges on the pin have no effect on the counter.
- R11: During reset `sync_phase` is 0, `sync_clk` is 1, `cfg_rdata` is 0 and `pin_oe` is 1.
- R12: `cfg_rdata` returns bits 0, 1 and 3 as last written, bit 2 as the pending request, and bit 24 as the error. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word and status readback |
| pll_locked | input | 1 | Lock indication from the PLL |
| pin_in | input | 1 | Shared pin, input side |
| pin_out | output | 1 | Shared pin, output value |
| pin_oe | output | 1 | Shared pin, output enable |
| sync_phase | output | 2 | Divider phase count |
| sync_clk | output | 1 | Divided synchronisation clock |

## Verification
The phase counter is exercised with single software requests, back-to-back requests, single and repeated pin edges in hardware mode, and master edges in automatic mode both with and without the extra synchroniser stage. Each pattern is started at a counter phase chosen so that a step, a reload and free counting give different values in the checked cycle. Edges applied in idle mode, and requests made under a higher-priority mode, separate "ignored" from "acted on". The lock-error tests cover a plain clear, a write that must not clear, and a clear that coincides with a new loss of lock.

// File: rtl/syncal_pkg.sv
package syncal_pkg;

  localparam int CFG_W        = 32;
  localparam int CFG_HS_BIT   = 0;
  localparam int CFG_HW_BIT   = 1;
  localparam int CFG_SW_BIT   = 2;
  localparam int CFG_AUTO_BIT = 3;
  localparam int CFG_ERR_BIT  = 24;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_HW   = 2'd2,
    SRC_AUTO = 2'd3
  } step_src_e;

  typedef struct packed {
    logic err;
    logic auto_en;
    logic sw_req;
    logic hw_en;
    logic hs_en;
  } cfg_t;

endpackage

// File: rtl/syncal_rst_sync.sv
module syncal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic meta_q;
  logic hold_q;

  // asynchronous assertion, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_ns = hold_q;

endmodule

// File: rtl/syncal_pin_sync.sv
module syncal_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic pin_i,
  output logic rise_fast,
  output logic rise_slow
);

  localparam int DEPTH = STAGES + 2;

  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = pin_i;
      end else begin : g_rest
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  // normal path: edge seen after STAGES flops; slow path adds one more
  assign rise_fast = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign rise_slow = chain_q[STAGES]   & ~chain_q[STAGES+1];

endmodule

// File: rtl/syncal_cfg.sv
module syncal_cfg
  import syncal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             pll_locked,
  input  logic             sw_consume,
  output cfg_t             cfg,
  output logic [CFG_W-1:0] rdata
);

  cfg_t cfg_q;
  cfg_t cfg_d;

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.hs_en   = wdata[CFG_HS_BIT];
      cfg_d.hw_en   = wdata[CFG_HW_BIT];
      cfg_d.auto_en = wdata[CFG_AUTO_BIT];
    end
    // request lives one cycle unless written again
    if (we && wdata[CFG_SW_BIT]) cfg_d.sw_req = 1'b1;
    else if (sw_consume)         cfg_d.sw_req = 1'b0;
    // sticky error: new loss of lock beats clear
    if (we && wdata[CFG_ERR_BIT]) cfg_d.err = 1'b0;
    if (!pll_locked)              cfg_d.err = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  always_comb begin
    rdata               = '0;
    rdata[CFG_HS_BIT]   = cfg_q.hs_en;
    rdata[CFG_HW_BIT]   = cfg_q.hw_en;
    rdata[CFG_SW_BIT]   = cfg_q.sw_req;
    rdata[CFG_AUTO_BIT] = cfg_q.auto_en;
    rdata[CFG_ERR_BIT]  = cfg_q.err;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/syncal_phase_div.sv
module syncal_phase_div #(
  parameter int CNT_W = 2,
  parameter int SKIP  = 1
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             adv,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] phase,
  output logic             div_clk
);

  localparam int DIV  = 1 << CNT_W;
  localparam int HALF = DIV / 2;
  localparam logic [CNT_W-1:0] INC_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] INC_STEP = CNT_W'(1 + SKIP);

  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] phase_d;
  logic             clk_q;
  logic             clk_d;

  always_comb begin
    if (load)     phase_d = load_val;
    else if (adv) phase_d = phase_q + INC_STEP;
    else          phase_d = phase_q + INC_ONE;
    clk_d = (int'(phase_d) < HALF);
  end

  // registered clock output keeps it free of decode glitches
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q <= '0;
      clk_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      clk_q   <= clk_d;
    end
  end

  assign phase   = phase_q;
  assign div_clk = clk_q;

endmodule

// File: rtl/syncclk_align.sv
module syncclk_align
  import syncal_pkg::*;
#(
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SKIP        = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             pll_locked,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic [CNT_W-1:0] sync_phase,
  output logic             sync_clk
);

  localparam int DIV = 1 << CNT_W;
  localparam logic [CNT_W-1:0] LOAD_BASE = CNT_W'(SYNC_STAGES % DIV);

  logic             rst_ns;
  logic             rise_fast;
  logic             rise_slow;
  logic             auto_rise;
  cfg_t             cfg;
  step_src_e        src;
  logic             adv;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] phase_q;

  syncal_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ns(rst_ns)
  );

  syncal_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .pin_i    (pin_in),
    .rise_fast(rise_fast),
    .rise_slow(rise_slow)
  );

  syncal_cfg u_cfg (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .pll_locked(pll_locked),
    .sw_consume(cfg.sw_req),
    .cfg       (cfg),
    .rdata     (cfg_rdata)
  );

  // fixed source priority
  always_comb begin
    if (cfg.auto_en)    src = SRC_AUTO;
    else if (cfg.hw_en) src = SRC_HW;
    else if (cfg.sw_req) src = SRC_SW;
    else                src = SRC_NONE;
  end

  assign auto_rise = cfg.hs_en ? rise_slow : rise_fast;
  assign adv       = ((src == SRC_HW) && rise_fast) || (src == SRC_SW);
  assign load      = (src == SRC_AUTO) && auto_rise;
  assign load_val  = LOAD_BASE + CNT_W'(cfg.hs_en);

  syncal_phase_div #(.CNT_W(CNT_W), .SKIP(SKIP)) u_div (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .adv     (adv),
    .load    (load),
    .load_val(load_val),
    .phase   (phase_q),
    .div_clk (sync_clk)
  );

  assign sync_phase = phase_q;
  assign pin_oe     = ~(cfg.auto_en | cfg.hw_en);
  assign pin_out    = pin_oe & pll_locked;

endmodule

// File: rtl/syncal_chk.sv
module syncal_chk #(
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SKIP        = 1
) (
  input logic             clk,
  input logic             rst_ns,
  input logic [CNT_W-1:0] phase,
  input logic             c_hs,
  input logic             c_hw,
  input logic             c_sw,
  input logic             c_auto,
  input logic             c_err,
  input logic             rise_fast,
  input logic             rise_slow,
  input logic             pin_oe,
  input logic             pin_out,
  input logic             pll_locked,
  input logic             we,
  input logic             w_sw,
  input logic             w_clr
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1 + SKIP);
  localparam logic [CNT_W-1:0] LD0  = CNT_W'(SYNC_STAGES);
  localparam logic [CNT_W-1:0] LD1  = CNT_W'(SYNC_STAGES + 1);

  a_r1_free_count: assert property (@(posedge clk) disable iff (!rst_ns)
    (!c_auto && !c_hw && !c_sw) |=> phase == $past(phase) + ONE);

  a_r2_sw_step: assert property (@(posedge clk) disable iff (!rst_ns)
    (c_sw && !c_auto && !c_hw) |=> phase == $past(phase) + STEP);

  a_r2_self_clear: assert property (@(posedge clk) disable iff (!rst_ns)
    (c_sw && !(we && w_sw)) |=> !c_sw);

  a_r4_hw_step: assert property (@(posedge clk) disable iff (!rst_ns)
    (c_hw && !c_auto && rise_fast) |=> phase == $past(phase) + STEP);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_ns)
    (c_auto && !c_hs && rise_fast) |=> phase == LD0);

  a_r6_reload_hs: assert property (@(posedge clk) disable iff (!rst_ns)
    (c_auto && c_hs && rise_slow) |=> phase == LD1);

  a_r7_sw_dropped: assert property (@(posedge clk) disable iff (!rst_ns)
    (c_sw && c_hw && !c_auto && !rise_fast) |=> phase == $past(phase) + ONE);

  a_r8_pin_input: assert property (@(posedge clk) disable iff (!rst_ns)
    (c_auto || c_hw) |-> (!pin_oe && !pin_out));

  a_r8_pin_output: assert property (@(posedge clk) disable iff (!rst_ns)
    (!c_auto && !c_hw) |-> (pin_oe && pin_out == pll_locked));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_ns)
    (c_err && !(we && w_clr)) |=> c_err);

  a_r9_set: assert property (@(posedge clk) disable iff (!rst_ns)
    !pll_locked |=> c_err);

endmodule

bind syncclk_align syncal_chk #(
  .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .SKIP(SKIP)
) chk_i (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .phase     (phase_q),
  .c_hs      (cfg.hs_en),
  .c_hw      (cfg.hw_en),
  .c_sw      (cfg.sw_req),
  .c_auto    (cfg.auto_en),
  .c_err     (cfg.err),
  .rise_fast (rise_fast),
  .rise_slow (rise_slow),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .pll_locked(pll_locked),
  .we        (cfg_we),
  .w_sw      (cfg_wdata[2]),
  .w_clr     (cfg_wdata[24])
);

// File: tb/syncclk_align_tb_top.sv
`timescale 1ns/1ps
module syncclk_align_tb_top;

  localparam logic [31:0] HS = 32'h1;
  localparam logic [31:0] HW = 32'h2;
  localparam logic [31:0] SW = 32'h4;
  localparam logic [31:0] AU = 32'h8;
  localparam logic [31:0] ER = 32'h0100_0000;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        pll_locked;
  logic        pin_in;
  logic        pin_out;
  logic        pin_oe;
  logic [1:0]  sync_phase;
  logic        sync_clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  bit mon_on = 0;

  typedef struct {
    int          at;
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];

  syncclk_align dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pll_locked(pll_locked), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .sync_phase(sync_phase),
    .sync_clk(sync_clk)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] probe(int sel);
    case (sel)
      0:       return {30'd0, sync_phase};
      1:       return cfg_rdata;
      2:       return {31'd0, pin_oe};
      3:       return {31'd0, pin_out};
      default: return {31'd0, sync_clk};
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver side: queue an expected value dc cycles ahead
  task automatic expect_at(int dc, int sel, logic [31:0] v, string req);
    item_t it;
    it.at = cyc + dc; it.sel = sel; it.exp = v; it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: sample 2 ns after each edge, compare due items
  always @(posedge clk) begin
    #2;
    cyc++;
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].at == cyc) begin
        check(probe(sb_q[i].sel), sb_q[i].exp, sb_q[i].req);
        sb_q.delete(i);
      end
    end
    if (mon_on) check({31'd0, sync_clk}, {31'd0, (sync_phase < 2'd2)}, "R1 clk");
  end

  task automatic cfg_write(logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ph(int v);
    return 32'(v % 4);
  endfunction

  task automatic wait_low_phase();
    while (sync_phase >= 2'd2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; pll_locked = 1'b1; pin_in = 1'b0;
    settle(3);
    // R11 reset state
    check({30'd0, sync_phase}, 32'd0, "R11 phase");
    check({31'd0, sync_clk}, 32'd1, "R11 clk");
    check(cfg_rdata, 32'd0, "R11 rdata");
    check({31'd0, pin_oe}, 32'd1, "R11 oe");
    rst_n = 1'b1;
    settle(6);
    mon_on = 1;

    // R1 free counting
    p = sync_phase;
    for (int k = 1; k <= 5; k++) expect_at(k, 0, ph(p + k), "R1");
    settle(7);

    // R2 single software step
    p = sync_phase;
    expect_at(1, 0, ph(p + 1), "R2");
    expect_at(2, 0, ph(p + 3), "R2");
    expect_at(3, 0, ph(p + 4), "R2");
    expect_at(1, 1, SW, "R2 req set");
    expect_at(2, 1, 32'd0, "R2 req clear");
    cfg_write(SW);
    settle(5);

    // R3 back-to-back requests
    p = sync_phase;
    expect_at(4, 0, ph(p + 6), "R3");
    expect_at(6, 0, ph(p + 8), "R3");
    cfg_write(SW);
    cfg_write(SW);
    settle(7);

    // R10 pin ignored in idle mode
    p = sync_phase;
    expect_at(6, 0, ph(p + 6), "R10");
    pin_in = 1'b1;
    settle(3);
    pin_in = 1'b0;
    settle(6);

    // R4 hardware step mode
    cfg_write(HW);
    settle(4);
    #1 check({31'd0, pin_oe}, 32'd0, "R8 oe hw");
    check({31'd0, pin_out}, 32'd0, "R8 out hw");
    @(negedge clk);
    p = sync_phase;
    expect_at(2, 0, ph(p + 2), "R4");
    expect_at(3, 0, ph(p + 4), "R4");
    expect_at(7, 0, ph(p + 8), "R4 held");
    pin_in = 1'b1;
    settle(7);
    pin_in = 1'b0;
    settle(4);
    p = sync_phase;
    expect_at(5, 0, ph(p + 6), "R4 second");
    pin_in = 1'b1;
    settle(6);
    pin_in = 1'b0;
    settle(4);

    // R7 software request under hardware mode is dropped
    p = sync_phase;
    expect_at(1, 1, HW | SW, "R7 req");
    expect_at(2, 1, HW, "R7 req drop");
    expect_at(3, 0, ph(p + 3), "R7 no step");
    cfg_write(HW | SW);
    settle(5);

    // R5 automatic alignment
    cfg_write(AU);
    settle(4);
    wait_low_phase();
    p = sync_phase;
    expect_at(3, 0, 32'd2, "R5 reload");
    expect_at(5, 0, 32'd0, "R5 wrap");
    expect_at(7, 0, 32'd2, "R5 after");
    pin_in = 1'b1;
    settle(8);
    pin_in = 1'b0;
    settle(4);
    // shift away, then realign from a new offset
    cfg_write(32'd0);
    cfg_write(SW);
    cfg_write(AU);
    settle(4);
    wait_low_phase();
    expect_at(3, 0, 32'd2, "R5 realign");
    expect_at(5, 0, 32'd0, "R5 realign");
    pin_in = 1'b1;
    settle(8);
    pin_in = 1'b0;
    settle(4);

    // R6 high-speed alignment
    cfg_write(AU | HS);
    settle(4);
    wait_low_phase();
    p = sync_phase;
    expect_at(3, 0, ph(p + 3), "R6 late");
    expect_at(4, 0, 32'd3, "R6 reload");
    expect_at(5, 0, 32'd0, "R6 wrap");
    pin_in = 1'b1;
    settle(8);
    pin_in = 1'b0;
    settle(4);

    // R7 automatic beats hardware step
    cfg_write(AU | HW);
    settle(4);
    wait_low_phase();
    expect_at(3, 0, 32'd2, "R7 auto wins");
    expect_at(5, 0, 32'd0, "R7 auto wins");
    pin_in = 1'b1;
    settle(8);
    pin_in = 1'b0;
    settle(4);

    // R12 readback of mode bits
    expect_at(1, 1, AU | HW | HS, "R12");
    cfg_write(32'h00F0_000B);
    settle(3);

    // R9 lock error in automatic mode
    cfg_write(AU);
    settle(2);
    expect_at(1, 1, AU | ER, "R9 set");
    expect_at(4, 1, AU | ER, "R9 sticky");
    pll_locked = 1'b0;
    @(negedge clk);
    pll_locked = 1'b1;
    settle(4);
    expect_at(2, 1, AU | ER, "R9 no clear");
    cfg_write(AU);
    settle(2);
    expect_at(1, 1, AU, "R9 clear");
    cfg_write(AU | ER);
    settle(3);

    // R8 pin drives lock in idle mode, R9 set beats clear
    cfg_write(32'd0);
    settle(2);
    pll_locked = 1'b0;
    #1 check({31'd0, pin_out}, 32'd0, "R8 out low");
    check({31'd0, pin_oe}, 32'd1, "R8 oe idle");
    expect_at(1, 1, ER, "R9 set wins");
    cfg_write(ER);
    pll_locked = 1'b1;
    #1 check({31'd0, pin_out}, 32'd1, "R8 out high");
    @(negedge clk);
    expect_at(1, 1, 32'd0, "R9 clear idle");
    cfg_write(ER);
    settle(2);

    // R8 pin stays an output while a software request is pending
    cfg_write(SW);
    #1 check({31'd0, pin_oe}, 32'd1, "R8 oe sw");
    settle(4);

    mon_on = 0;
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard act=%0d exp=0 items left", sb_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule